// File: doc/BRIEF.md
# RF Channel Tuning Write Sequencer

This block turns a request to move a 2.4 GHz transceiver to one of channels 1 to 14 into a fixed series of 24-bit register writes. It passes each write to a downstream 3-wire shifter as one frame. A frame is offered with a valid/ready handshake. The block then waits for the shifter's completion pulse before it offers the next frame. Together with the channel, the requester supplies three things: the VCO configuration set found by an earlier calibration, a flag that selects the fixed autocal tuning, and the transmit power index for that channel.

Every frame value comes from small lookup functions inside the block. These cover the synthesizer word (a short one for standard mode, a long one for autocal), the fractional divide ratio, the VCO word and the TX gain word. The VCO word depends on both the channel pair and the calibration set. The sequence writes the synthesizer, divider and VCO registers. It then cycles the transceiver through four operating-mode words and finishes with the gain write. The gain write is left out when the power index is out of range.

Top module: `rf_tune_seq`

## Requirements
- R1: Each frame carries the register address in bits [23:20] and the 20-bit register value in bits [19:0]; the address is never above 7.
- R2: An accepted request for channel c produces frames to registers 1, 2, 3, 0, 0, 0, 0, 7, in that order (the last one only when R7 allows it).
- R3: In standard mode, register 1 takes 0x47 for channels 1-2, 0x67 for 3-6, 0x57 for 7-10, 0x77 for 11-13 and 0x4f for 14. In both modes, register 2 takes 0x999, 0x99b, 0x998, 0x99a for channels 1+4k, 2+4k, 3+4k, 4+4k (channels 1 to 13), and 0xccc for channel 14.
- R4: With the autocal flag set, register 1 takes 0x6800 plus the R3 standard value, and register 3 takes 0x46662 for every channel.
- R5: In standard mode, register 3 takes 0x40000 ORed with the 16-bit VCO entry of calibration set s (0 to 10) at pair index (c-1)/2. A set input above 10 is treated as set 10.
- R6: The four register 0 values are, in order, 0x25f98, 0x25f9a, 0x25f94 and 0x27fd4.
- R7: Register 7 takes the gain word at power index p (0 to 18), from the 19-entry gain table. For p of 19 or more, no register 7 frame is sent, and the sequence ends after the seventh frame without any error indication.
- R8: A request for channel 0 or 15 raises reqError for exactly one cycle, the cycle after the request. Busy stays low and no frame is offered.
- R9: busy rises in the cycle after an accepted request and falls in the cycle after the completion pulse of the final frame. Requests that arrive while busy is high are ignored.
- R10: While frameValid is high and frameReady is low, frameValid stays high and frameData stays unchanged. No new frame is offered until frameDone has been seen for the previous one.
- R11: After reset, frameValid, busy and reqError are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Channel-change request strobe |
| reqChannel | input | 4 | Requested channel, 1 to 14 valid |
| vcoSet | input | 4 | Calibrated VCO configuration set |
| autocal | input | 1 | Use fixed autocal tuning words |
| pwrIndex | input | 5 | TX power index for the channel |
| frameValid | output | 1 | Frame offered to the shifter |
| frameData | output | 24 | Address and value of the offered frame |
| frameReady | input | 1 | Shifter accepts the offered frame |
| frameDone | input | 1 | Shifter finished sending the accepted frame |
| busy | output | 1 | Sequence in progress |
| reqError | output | 1 | Pulse on a rejected channel |

## Verification
The first frame is offered one cycle after the request is sampled. Each later frame is offered one cycle after the completion pulse of the frame before it. busy and reqError change one cycle after their causes, and busy falls one cycle after the last completion. The bench drives every input at the falling edge. It records a frame only at a falling edge where valid and ready are both high, so every frame it records is transferred at the next rising edge. It checks busy and reqError at the first falling edge after the triggering rising edge. It compares the recorded frame list, entry by entry, with a list built from its own tables.

// File: rtl/rf_tune_pkg.sv
package rf_tune_pkg;

  localparam int ADDR_W   = 4;
  localparam int VAL_W    = 20;
  localparam int FRAME_W  = ADDR_W + VAL_W;
  localparam int CHAN_W   = 4;
  localparam int SET_W    = 4;
  localparam int PWR_W    = 5;
  localparam int NUM_CHAN = 14;
  localparam int NUM_SETS = 11;
  localparam int GAIN_ENTRIES = 19;
  localparam logic [VAL_W-1:0] VCO_FLAG = 20'h40000;
  localparam logic [15:0] AUTO_VCO = 16'h6662;

  typedef enum logic [2:0] {
    ST_SYN   = 3'd0,
    ST_DIV   = 3'd1,
    ST_VCO   = 3'd2,
    ST_IDLEM = 3'd3,
    ST_CALM  = 3'd4,
    ST_RUNM  = 3'd5,
    ST_RSSIM = 3'd6,
    ST_GAIN  = 3'd7
  } step_e;

  typedef struct packed {
    logic  latchReq;
    step_e step;
  } ctlStrobe_t;

  function automatic logic [7:0] stdSynth(input logic [CHAN_W-1:0] ch);
    if (ch <= 4'd2)       return 8'h47;
    else if (ch <= 4'd6)  return 8'h67;
    else if (ch <= 4'd10) return 8'h57;
    else if (ch <= 4'd13) return 8'h77;
    else                  return 8'h4f;
  endfunction

  function automatic logic [11:0] divRatio(input logic [CHAN_W-1:0] ch);
    logic [3:0] m;
    m = ch - 4'd1;
    if (ch == 4'd14) return 12'hccc;
    case (m[1:0])
      2'd0:    return 12'h999;
      2'd1:    return 12'h99b;
      2'd2:    return 12'h998;
      default: return 12'h99a;
    endcase
  endfunction

  // Low byte progression shared by all sets; each set is shifted by one step.
  function automatic logic [7:0] vcoLow(input logic [3:0] k);
    case (k)
      4'd0:  return 8'h65;
      4'd1:  return 8'h55;
      4'd2:  return 8'h75;
      4'd3:  return 8'h4d;
      4'd4:  return 8'h6d;
      4'd5:  return 8'h5d;
      4'd6:  return 8'h7d;
      4'd7:  return 8'h43;
      4'd8:  return 8'h63;
      4'd9:  return 8'h53;
      4'd10: return 8'h73;
      4'd11: return 8'h4b;
      4'd12: return 8'h6b;
      default: return 8'h5b;
    endcase
  endfunction

  function automatic logic [15:0] vcoEntry(input logic [SET_W-1:0] set,
                                           input logic [2:0] pair);
    logic [3:0] k;
    logic [7:0] hi;
    k = set + 4'd3 - {2'b00, pair[2:1]};
    if (pair == 3'd1)     hi = 8'h60;
    else if (pair[0])     hi = 8'h64;
    else                  hi = 8'h66;
    return {hi, vcoLow(k)};
  endfunction

  function automatic logic [19:0] gainWord(input logic [PWR_W-1:0] idx);
    case (idx)
      5'd0:  return 20'h0e313;
      5'd1:  return 20'h0fb13;
      5'd2:  return 20'h0e093;
      5'd3:  return 20'h0f893;
      5'd4:  return 20'h0ea93;
      5'd5:  return 20'h1f093;
      5'd6:  return 20'h1f493;
      5'd7:  return 20'h1f693;
      5'd8:  return 20'h1f393;
      5'd9:  return 20'h1f35b;
      5'd10: return 20'h1e6db;
      5'd11: return 20'h1ff3f;
      5'd12: return 20'h1ffff;
      5'd13: return 20'h361d7;
      5'd14: return 20'h37fbf;
      5'd15: return 20'h3ff8b;
      5'd16: return 20'h3ff33;
      5'd17: return 20'h3fb3f;
      default: return 20'h3ffff;
    endcase
  endfunction

endpackage

// File: rtl/rf_tune_dp.sv
module rf_tune_dp
  import rf_tune_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         ctl,
  input  logic [CHAN_W-1:0]  reqChannel,
  input  logic [SET_W-1:0]   vcoSet,
  input  logic               autocal,
  input  logic [PWR_W-1:0]   pwrIndex,
  output logic               chanOk,
  output logic               gainSkip,
  output logic [FRAME_W-1:0] frameData
);

  localparam logic [SET_W-1:0] LAST_SET = SET_W'(NUM_SETS - 1);

  logic [CHAN_W-1:0] chanL;
  logic [SET_W-1:0]  setL;
  logic              autoL;
  logic [PWR_W-1:0]  pwrL;
  logic [2:0]        pairIdx;
  logic [3:0]        addr;
  logic [VAL_W-1:0]  value;

  assign chanOk = (reqChannel >= CHAN_W'(1)) && (reqChannel <= CHAN_W'(NUM_CHAN));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanL    <= CHAN_W'(1);
      setL     <= '0;
      autoL    <= 1'b0;
      pwrL     <= '0;
      gainSkip <= 1'b0;
    end else if (ctl.latchReq) begin
      chanL    <= reqChannel;
      setL     <= (vcoSet > LAST_SET) ? LAST_SET : vcoSet;
      autoL    <= autocal;
      pwrL     <= pwrIndex;
      gainSkip <= (pwrIndex >= PWR_W'(GAIN_ENTRIES));
    end
  end

  always_comb begin
    logic [3:0] cm1;
    cm1 = chanL - 4'd1;
    pairIdx = cm1[3:1];
  end

  always_comb begin
    addr  = 4'd0;
    value = '0;
    case (ctl.step)
      ST_SYN: begin
        addr  = 4'd1;
        value = autoL ? {4'h0, 8'h68, stdSynth(chanL)} : {12'h000, stdSynth(chanL)};
      end
      ST_DIV: begin
        addr  = 4'd2;
        value = {8'h00, divRatio(chanL)};
      end
      ST_VCO: begin
        addr  = 4'd3;
        value = VCO_FLAG | {4'h0, (autoL ? AUTO_VCO : vcoEntry(setL, pairIdx))};
      end
      ST_IDLEM: value = 20'h25f98;
      ST_CALM:  value = 20'h25f9a;
      ST_RUNM:  value = 20'h25f94;
      ST_RSSIM: value = 20'h27fd4;
      ST_GAIN: begin
        addr  = 4'd7;
        value = gainWord(pwrL);
      end
      default: ;
    endcase
  end

  assign frameData = {addr, value};

  // R1: address field stays inside the eight device registers
  assert_addr_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    frameData[23:20] <= 4'd7);

  // R5: the VCO frame always carries the fixed upper flag
  assert_vco_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step == ST_VCO) |-> (frameData[23:20] == 4'd3 && frameData[18]));

endmodule

// File: rtl/rf_tune_ctrl.sv
module rf_tune_ctrl
  import rf_tune_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       chanOk,
  input  logic       gainSkip,
  input  logic       frameReady,
  input  logic       frameDone,
  output ctlStrobe_t ctl,
  output logic       frameValid,
  output logic       busy,
  output logic       reqError
);

  typedef enum logic [1:0] {C_IDLE, C_OFFER, C_WAIT} cstate_e;

  cstate_e state;
  step_e   step;
  logic    lastStep;

  assign lastStep = (step == ST_GAIN) || (step == ST_RSSIM && gainSkip);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= C_IDLE;
      step     <= ST_SYN;
      reqError <= 1'b0;
    end else begin
      reqError <= 1'b0;
      case (state)
        C_IDLE: if (reqValid) begin
          if (chanOk) begin
            state <= C_OFFER;
            step  <= ST_SYN;
          end else begin
            reqError <= 1'b1;
          end
        end
        C_OFFER: if (frameReady) state <= C_WAIT;
        C_WAIT: if (frameDone) begin
          if (lastStep) begin
            state <= C_IDLE;
          end else begin
            step  <= step_e'(step + 3'd1);
            state <= C_OFFER;
          end
        end
        default: state <= C_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.latchReq = (state == C_IDLE) && reqValid && chanOk;
    ctl.step     = step;
  end

  assign frameValid = (state == C_OFFER);
  assign busy       = (state != C_IDLE);

  // R10: an offered frame is withdrawn only after it is taken
  assert_hold_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && !frameReady) |=> frameValid);

  // R10: a taken frame is followed by a wait, never by another offer
  assert_wait_after_take_R10: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && frameReady) |=> !frameValid);

  // R9: nothing is offered outside a sequence
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !frameValid);

  // R8: a rejection never starts a sequence
  assert_reject_no_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqError |-> !busy);

endmodule

// File: rtl/rf_tune_seq.sv
module rf_tune_seq
  import rf_tune_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [CHAN_W-1:0]  reqChannel,
  input  logic [SET_W-1:0]   vcoSet,
  input  logic               autocal,
  input  logic [PWR_W-1:0]   pwrIndex,
  output logic               frameValid,
  output logic [FRAME_W-1:0] frameData,
  input  logic               frameReady,
  input  logic               frameDone,
  output logic               busy,
  output logic               reqError
);

  ctlStrobe_t ctl;
  logic       chanOk;
  logic       gainSkip;

  rf_tune_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .chanOk     (chanOk),
    .gainSkip   (gainSkip),
    .frameReady (frameReady),
    .frameDone  (frameDone),
    .ctl        (ctl),
    .frameValid (frameValid),
    .busy       (busy),
    .reqError   (reqError)
  );

  rf_tune_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqChannel (reqChannel),
    .vcoSet     (vcoSet),
    .autocal    (autocal),
    .pwrIndex   (pwrIndex),
    .chanOk     (chanOk),
    .gainSkip   (gainSkip),
    .frameData  (frameData)
  );

  // R10: a stalled frame keeps its contents
  assert_data_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && !frameReady) |=> $stable(frameData));

endmodule

// File: tb/rf_tune_seq_bench.sv
module rf_tune_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [3:0]  reqChannel = 4'd1;
  logic [3:0]  vcoSet = 4'd0;
  logic        autocal = 1'b0;
  logic [4:0]  pwrIndex = 5'd0;
  logic        frameValid;
  logic [23:0] frameData;
  logic        frameReady = 1'b1;
  logic        frameDone = 1'b0;
  logic        busy;
  logic        reqError;

  int checks = 0;
  int fails = 0;
  logic [23:0] got [0:31];
  int gotN = 0;
  int pend = 0;

  always #5 clk = ~clk;

  rf_tune_seq u_rf_tune_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqChannel(reqChannel),
    .vcoSet(vcoSet), .autocal(autocal), .pwrIndex(pwrIndex),
    .frameValid(frameValid), .frameData(frameData), .frameReady(frameReady),
    .frameDone(frameDone), .busy(busy), .reqError(reqError));

  // Downstream shifter model: record taken frames, answer three cycles later.
  always @(negedge clk) begin
    frameDone = 1'b0;
    if (pend > 0) begin
      pend = pend - 1;
      if (pend == 0) frameDone = 1'b1;
    end
    if (frameValid && frameReady) begin
      if (gotN < 32) got[gotN] = frameData;
      gotN = gotN + 1;
      pend = 3;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] refSynth(input int ch, input bit ac);
    logic [7:0] s;
    case (ch)
      1, 2: s = 8'h47;
      3, 4, 5, 6: s = 8'h67;
      7, 8, 9, 10: s = 8'h57;
      11, 12, 13: s = 8'h77;
      default: s = 8'h4f;
    endcase
    return ac ? {8'h68, s} : {8'h00, s};
  endfunction

  function automatic logic [11:0] refDiv(input int ch);
    case (ch)
      1, 5, 9, 13: return 12'h999;
      2, 6, 10: return 12'h99b;
      3, 7, 11: return 12'h998;
      4, 8, 12: return 12'h99a;
      default: return 12'hccc;
    endcase
  endfunction

  function automatic logic [15:0] refVco(input int set, input int ch);
    logic [111:0] row;
    int p;
    case (set)
      0:  row = {16'h664d,16'h604d,16'h6675,16'h6475,16'h6655,16'h6455,16'h6665};
      1:  row = {16'h666d,16'h606d,16'h664d,16'h644d,16'h6675,16'h6475,16'h6655};
      2:  row = {16'h665d,16'h605d,16'h666d,16'h646d,16'h664d,16'h644d,16'h6675};
      3:  row = {16'h667d,16'h607d,16'h665d,16'h645d,16'h666d,16'h646d,16'h664d};
      4:  row = {16'h6643,16'h6043,16'h667d,16'h647d,16'h665d,16'h645d,16'h666d};
      5:  row = {16'h6663,16'h6063,16'h6643,16'h6443,16'h667d,16'h647d,16'h665d};
      6:  row = {16'h6653,16'h6053,16'h6663,16'h6463,16'h6643,16'h6443,16'h667d};
      7:  row = {16'h6673,16'h6073,16'h6653,16'h6453,16'h6663,16'h6463,16'h6643};
      8:  row = {16'h664b,16'h604b,16'h6673,16'h6473,16'h6653,16'h6453,16'h6663};
      9:  row = {16'h666b,16'h606b,16'h664b,16'h644b,16'h6673,16'h6473,16'h6653};
      default: row = {16'h665b,16'h605b,16'h666b,16'h646b,16'h664b,16'h644b,16'h6673};
    endcase
    p = (ch - 1) / 2;
    return row[111 - 16*p -: 16];
  endfunction

  function automatic logic [19:0] refGain(input int idx);
    logic [19:0] t [0:18];
    t = '{20'h0e313,20'h0fb13,20'h0e093,20'h0f893,20'h0ea93,20'h1f093,20'h1f493,
          20'h1f693,20'h1f393,20'h1f35b,20'h1e6db,20'h1ff3f,20'h1ffff,20'h361d7,
          20'h37fbf,20'h3ff8b,20'h3ff33,20'h3fb3f,20'h3ffff};
    return t[idx];
  endfunction

  task automatic pulseReq(input int ch, input int set, input bit ac, input int pwr);
    @(negedge clk);
    reqChannel = 4'(ch); vcoSet = 4'(set); autocal = ac; pwrIndex = 5'(pwr);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // One full tuning run, compared frame by frame (R1..R7, R9)
  task automatic runChan(input int ch, input int set, input bit ac, input int pwr);
    logic [23:0] exp [0:7];
    int n;
    int es;
    es = (set > 10) ? 10 : set;
    exp[0] = {4'd1, 4'h0, refSynth(ch, ac)};
    exp[1] = {4'd2, 8'h00, refDiv(ch)};
    exp[2] = {4'd3, 20'h40000 | {4'h0, (ac ? 16'h6662 : refVco(es, ch))}};
    exp[3] = {4'd0, 20'h25f98};
    exp[4] = {4'd0, 20'h25f9a};
    exp[5] = {4'd0, 20'h25f94};
    exp[6] = {4'd0, 20'h27fd4};
    exp[7] = (pwr < 19) ? {4'd7, refGain(pwr)} : 24'h0;
    n = (pwr < 19) ? 8 : 7;
    gotN = 0;
    pulseReq(ch, set, ac, pwr);
    chk(busy === 1'b1, "R9 busy after accept", 32'(busy), 1);
    waitIdle();
    chk(gotN == n, "R2/R7 frame count", 32'(gotN), 32'(n));
    for (int i = 0; i < 8; i++) begin
      if (i < n && i < gotN) begin
        if (i == 0) chk(got[i] === exp[i], ac ? "R4 synth" : "R3 synth", got[i], exp[i]);
        else if (i == 1) chk(got[i] === exp[i], "R3 divide", got[i], exp[i]);
        else if (i == 2) chk(got[i] === exp[i], ac ? "R4 vco" : "R5 vco", got[i], exp[i]);
        else if (i < 7) chk(got[i] === exp[i], "R6 mode word", got[i], exp[i]);
        else chk(got[i] === exp[i], "R7 gain", got[i], exp[i]);
      end
    end
  endtask

  task automatic testReset();
    chk(frameValid === 1'b0, "R11 valid low", 32'(frameValid), 0);
    chk(busy === 1'b0, "R11 busy low", 32'(busy), 0);
    chk(reqError === 1'b0, "R11 error low", 32'(reqError), 0);
  endtask

  task automatic testReject(input int ch);
    gotN = 0;
    pulseReq(ch, 0, 1'b0, 3);
    chk(reqError === 1'b1, "R8 error pulse", 32'(reqError), 1);
    chk(busy === 1'b0, "R8 not busy", 32'(busy), 0);
    @(negedge clk);
    chk(reqError === 1'b0, "R8 single pulse", 32'(reqError), 0);
    repeat (10) @(negedge clk);
    chk(gotN == 0, "R8 no frames", 32'(gotN), 0);
  endtask

  task automatic testIgnoreBusy();
    gotN = 0;
    pulseReq(3, 2, 1'b0, 4);
    repeat (4) @(negedge clk);
    reqChannel = 4'd9; autocal = 1'b1; pwrIndex = 5'd0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    waitIdle();
    repeat (20) @(negedge clk);
    chk(gotN == 8, "R9 ignored request count", 32'(gotN), 8);
    chk(got[0] === {4'd1, 20'h00067}, "R9 first request kept", got[0], {4'd1, 20'h00067});
    chk(got[2] === {4'd3, 20'h4605d}, "R9 latched set kept", got[2], {4'd3, 20'h4605d});
  endtask

  task automatic testStall();
    logic [23:0] first;
    gotN = 0;
    frameReady = 1'b0;
    pulseReq(5, 1, 1'b0, 2);
    first = frameData;
    chk(frameValid === 1'b1, "R10 offered", 32'(frameValid), 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(frameValid === 1'b1 && frameData === first, "R10 held while stalled",
          frameData, first);
    end
    chk(first === {4'd1, 20'h00067}, "R1 stalled frame fields", first, {4'd1, 20'h00067});
    frameReady = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(frameValid === 1'b0, "R10 no offer before done", 32'(frameValid), 0);
    waitIdle();
    chk(gotN == 8, "R10 full run after stall", 32'(gotN), 8);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    for (int s = 0; s < 11; s += 3)
      for (int c = 1; c <= 14; c++) runChan(c, s, 1'b0, (c + s) % 19);
    for (int c = 1; c <= 14; c++) runChan(c, 0, 1'b1, c + 4);
    runChan(7, 15, 1'b0, 18);
    runChan(14, 10, 1'b0, 19);
    runChan(1, 4, 1'b1, 31);
    testReject(0);
    testReject(15);
    testIgnoreBusy();
    testStall();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule